// File: doc/BRIEF.md
# Matrix Converter Interval Decoder with Overcurrent Trip

This block sits between the switching-time calculator and the commutation sequencers of a three-phase to three-phase matrix converter driven by combined output-voltage and input-current space vector modulation. In every switching period the calculator raises four boundary compare signals one after another. Together they split the period into five intervals. The calculator also supplies a 6-bit mode code that holds the active output-voltage sector and the active input-current sector. From these, the block decides which interval is running. For each output phase it then emits a registered 2-bit code that names the input phase to connect.

The four active intervals come from the two adjacent voltage vectors (first and second) combined with the two adjacent current vectors (leading and trailing). They always run in the same order. The fifth interval is a zero state: all three outputs go to one input phase, and that phase is chosen per mode. An overcurrent latch overrides everything and holds the outputs in the zero state until software clears the latch.

Top module: `mxc_pulse_decoder`

## Requirements
- R1: While `rst` is high at a rising clock edge, all three selection outputs become code 0 (input a) after that edge and `trip_active` becomes low.
- R2: `mode_code[5:3]` carries the output-voltage sector and `mode_code[2:0]` the input-current sector. Each sector is coded 1 to 6. Phase codes are a=0, b=1 and c=2. The selection outputs are registered and reflect the inputs seen at the previous rising edge.
- R3: `bnd_cmp[i]` high means that boundary i+1 of the period has passed. The running interval is 1 plus the index of the highest set bit, or 0 when no bit is set. This holds even for patterns that are not thermometer codes.
- R4: Voltage vector k (1..6) puts these outputs on the positive rail: 1:A, 2:A,B, 3:B, 4:B,C, 5:C, 6:A,C. Every other output goes on the negative rail. Output sector s uses first vector s-1 (6 when s=1) and second vector s. Current vector k gives the (positive, negative) input phases 1:(a,c), 2:(b,c), 3:(b,a), 4:(c,a), 5:(c,b), 6:(a,b). Input sector s uses leading vector s-1 (6 when s=1) and trailing vector s. The intervals 0 to 3 apply these pairs in order: first/leading, second/leading, second/trailing, first/trailing. For example, mode (1,1) in interval 0 gives A=a, B=b, C=a.
- R5: In interval 4, all three outputs select the input phase shared by the leading and trailing current vectors of the input sector.
- R6: If either sector field is 0 or 7, all three outputs select input a.
- R7: `oc_event` high at an edge sets `trip_active` after that edge. From that same edge, all outputs select input a, whatever the intervals and mode.
- R8: The trip stays latched until `trip_reset` is high while `oc_event` is low. When both are high, `oc_event` wins. The outputs stay at input a through the clearing edge and follow the normal mapping from the next edge.
- R9: While `bnd_cmp`, `mode_code` and the trip state stay constant, the selection outputs do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bnd_cmp | input | 4 | Interval boundary compare flags, bit i = boundary i+1 passed |
| mode_code | input | 6 | {output-voltage sector, input-current sector}, each 1..6 |
| oc_event | input | 1 | Overcurrent detection, sets the trip latch |
| trip_reset | input | 1 | Clears the trip latch when no overcurrent is present |
| sel_a | output | 2 | Input phase selected for output A |
| sel_b | output | 2 | Input phase selected for output B |
| sel_c | output | 2 | Input phase selected for output C |
| trip_active | output | 1 | Trip latch state |

## Verification
The hardest situation to reach from the ports is the handover when the trip clears. The latch has already dropped, but the outputs must still show the forced zero state for one more edge and only then return to the mapped selection. The stimulus first trips the block in a mode whose normal output is not all input a. It then raises `trip_reset` together with `oc_event` to show that the set wins. After that it drops `oc_event` with the reset still high, and samples both the edge that clears the latch and the edge after it. Non-thermometer compare patterns and out-of-range sector codes are applied right after modes with non-zero outputs, so a wrong decode shows up as a changed output.

// File: rtl/mxc_pd_pkg.sv
package mxc_pd_pkg;

    localparam int NUM_BND = 4;
    localparam int NUM_IV  = NUM_BND + 1;
    localparam int IV_W    = $clog2(NUM_IV);
    localparam int SEC_W   = 3;
    localparam int MODE_W  = 2 * SEC_W;
    localparam int NUM_PH  = 3;
    localparam int PH_W    = 2;
    localparam int NUM_SEC = 6;

    typedef enum logic [PH_W-1:0] {
        PH_A = 2'd0,
        PH_B = 2'd1,
        PH_C = 2'd2
    } phase_e;

    typedef enum logic [IV_W-1:0] {
        IV_FL   = 3'd0,   // first voltage, leading current
        IV_SL   = 3'd1,   // second voltage, leading current
        IV_ST   = 3'd2,   // second voltage, trailing current
        IV_FT   = 3'd3,   // first voltage, trailing current
        IV_ZERO = 3'd4
    } intv_e;

    typedef struct packed {
        phase_e ph_a;
        phase_e ph_b;
        phase_e ph_c;
    } sel_t;

    typedef struct packed {
        phase_e pos;
        phase_e neg;
    } rail_t;

    typedef struct packed {
        logic [SEC_W-1:0] vsec;
        logic [SEC_W-1:0] csec;
    } mode_t;

    function automatic logic sec_ok(input logic [SEC_W-1:0] s);
        return (s >= SEC_W'(1)) && (s <= SEC_W'(NUM_SEC));
    endfunction

    // zero-based vector index that follows k around the hexagon
    function automatic logic [SEC_W-1:0] hex_next(input logic [SEC_W-1:0] k);
        return (k == SEC_W'(NUM_SEC - 1)) ? '0 : k + SEC_W'(1);
    endfunction

    // positive-rail mask {A,B,C}; index 0 stands for vector 6
    function automatic logic [NUM_PH-1:0] volt_mask(input logic [SEC_W-1:0] vi);
        case (vi)
            3'd0:    return 3'b101;
            3'd1:    return 3'b100;
            3'd2:    return 3'b110;
            3'd3:    return 3'b010;
            3'd4:    return 3'b011;
            default: return 3'b001;
        endcase
    endfunction

    // rail phases of a current vector; index 0 stands for vector 6
    function automatic rail_t cur_rails(input logic [SEC_W-1:0] ci);
        rail_t r;
        case (ci)
            3'd0:    begin r.pos = PH_A; r.neg = PH_B; end
            3'd1:    begin r.pos = PH_A; r.neg = PH_C; end
            3'd2:    begin r.pos = PH_B; r.neg = PH_C; end
            3'd3:    begin r.pos = PH_B; r.neg = PH_A; end
            3'd4:    begin r.pos = PH_C; r.neg = PH_A; end
            default: begin r.pos = PH_C; r.neg = PH_B; end
        endcase
        return r;
    endfunction

    function automatic phase_e shared_phase(input rail_t x, input rail_t y);
        return ((x.pos == y.pos) || (x.pos == y.neg)) ? x.pos : x.neg;
    endfunction

    function automatic sel_t combine(input logic [NUM_PH-1:0] m, input rail_t r);
        sel_t s;
        s.ph_a = m[2] ? r.pos : r.neg;
        s.ph_b = m[1] ? r.pos : r.neg;
        s.ph_c = m[0] ? r.pos : r.neg;
        return s;
    endfunction

    function automatic sel_t all_to(input phase_e p);
        sel_t s;
        s.ph_a = p;
        s.ph_b = p;
        s.ph_c = p;
        return s;
    endfunction

endpackage

// File: rtl/mxc_interval_dec.sv
module mxc_interval_dec
    import mxc_pd_pkg::*;
#(
    parameter int NB = NUM_BND
) (
    input  logic [NB-1:0] bnd_cmp,
    output intv_e         iv
);
    localparam int IW = $clog2(NB + 1);

    logic [IW-1:0] idx;

    // highest passed boundary wins
    always_comb begin
        idx = '0;
        for (int i = 0; i < NB; i++) begin
            if (bnd_cmp[i]) idx = IW'(i + 1);
        end
    end

    assign iv = intv_e'(idx);
endmodule

// File: rtl/mxc_mode_map.sv
module mxc_mode_map
    import mxc_pd_pkg::*;
(
    input  mode_t mode,
    input  intv_e iv,
    output sel_t  sel
);
    logic [SEC_W-1:0]  kv, kc;
    logic [NUM_PH-1:0] m_first, m_second;
    rail_t             r_lead, r_trail;
    logic              valid;

    assign valid    = sec_ok(mode.vsec) && sec_ok(mode.csec);
    assign kv       = mode.vsec - SEC_W'(1);
    assign kc       = mode.csec - SEC_W'(1);
    assign m_first  = volt_mask(kv);
    assign m_second = volt_mask(hex_next(kv));
    assign r_lead   = cur_rails(kc);
    assign r_trail  = cur_rails(hex_next(kc));

    always_comb begin
        if (!valid) begin
            sel = all_to(PH_A);
        end else begin
            case (iv)
                IV_FL:   sel = combine(m_first,  r_lead);
                IV_SL:   sel = combine(m_second, r_lead);
                IV_ST:   sel = combine(m_second, r_trail);
                IV_FT:   sel = combine(m_first,  r_trail);
                default: sel = all_to(shared_phase(r_lead, r_trail));
            endcase
        end
    end
endmodule

// File: rtl/mxc_trip_latch.sv
module mxc_trip_latch (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic q,
    output logic force_o
);
    always_ff @(posedge clk) begin
        if (rst)        q <= 1'b0;
        else if (set_i) q <= 1'b1;
        else if (clr_i) q <= 1'b0;
    end

    assign force_o = set_i | q;
endmodule

// File: rtl/mxc_pulse_decoder.sv
module mxc_pulse_decoder
    import mxc_pd_pkg::*;
#(
    parameter int NB = NUM_BND
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NB-1:0]     bnd_cmp,
    input  logic [MODE_W-1:0] mode_code,
    input  logic              oc_event,
    input  logic              trip_reset,
    output logic [PH_W-1:0]   sel_a,
    output logic [PH_W-1:0]   sel_b,
    output logic [PH_W-1:0]   sel_c,
    output logic              trip_active
);
    intv_e iv;
    sel_t  map_sel, nxt_sel;
    logic  force_zero;

    logic [NUM_PH-1:0][PH_W-1:0] nxt_flat;
    logic [NUM_PH-1:0][PH_W-1:0] sel_q;

    mxc_interval_dec #(.NB(NB)) u_ivdec (
        .bnd_cmp (bnd_cmp),
        .iv      (iv)
    );

    mxc_mode_map u_map (
        .mode (mode_t'(mode_code)),
        .iv   (iv),
        .sel  (map_sel)
    );

    mxc_trip_latch u_trip (
        .clk     (clk),
        .rst     (rst),
        .set_i   (oc_event),
        .clr_i   (trip_reset),
        .q       (trip_active),
        .force_o (force_zero)
    );

    assign nxt_sel  = force_zero ? all_to(PH_A) : map_sel;
    assign nxt_flat = nxt_sel;

    for (genvar g = 0; g < NUM_PH; g++) begin : g_phase_reg
        always_ff @(posedge clk) begin
            if (rst) sel_q[g] <= PH_W'(PH_A);
            else     sel_q[g] <= nxt_flat[g];
        end
    end

    assign sel_a = sel_q[2];
    assign sel_b = sel_q[1];
    assign sel_c = sel_q[0];
endmodule

// File: rtl/mxc_pulse_decoder_chk.sv
module mxc_pulse_decoder_chk
    import mxc_pd_pkg::*;
#(
    parameter int NB = NUM_BND
) (
    input logic              clk,
    input logic              rst,
    input logic [NB-1:0]     bnd_cmp,
    input logic [MODE_W-1:0] mode_code,
    input logic              oc_event,
    input logic              trip_reset,
    input logic [PH_W-1:0]   sel_a,
    input logic [PH_W-1:0]   sel_b,
    input logic [PH_W-1:0]   sel_c,
    input logic              trip_active
);
    logic prev_rst;
    logic mode_valid;

    always_ff @(posedge clk) prev_rst <= rst;

    assign mode_valid = sec_ok(mode_code[MODE_W-1:SEC_W]) && sec_ok(mode_code[SEC_W-1:0]);

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (sel_a == 2'd0 && sel_b == 2'd0 && sel_c == 2'd0 && !trip_active)); // R1

    AST_TRIP_SETS: assert property (@(posedge clk) disable iff (rst)
        oc_event |=> trip_active); // R7

    AST_TRIP_FORCES_A: assert property (@(posedge clk) disable iff (rst)
        (oc_event || trip_active) |=> (sel_a == 2'd0 && sel_b == 2'd0 && sel_c == 2'd0)); // R7

    AST_TRIP_STICKY: assert property (@(posedge clk) disable iff (rst)
        (trip_active && !trip_reset) |=> trip_active); // R8

    AST_TRIP_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (oc_event && trip_reset) |=> trip_active); // R8

    AST_ZERO_COMMON: assert property (@(posedge clk) disable iff (rst)
        bnd_cmp[NB-1] |=> (sel_a == sel_b && sel_b == sel_c)); // R5

    AST_ACTIVE_TWO_PHASES: assert property (@(posedge clk) disable iff (rst)
        (mode_valid && !bnd_cmp[NB-1] && !oc_event && !trip_active)
        |=> (!(sel_a == sel_b && sel_b == sel_c)
             && (sel_a == sel_b || sel_b == sel_c || sel_a == sel_c))); // R4

    AST_INVALID_MODE: assert property (@(posedge clk) disable iff (rst)
        !mode_valid |=> (sel_a == 2'd0 && sel_b == 2'd0 && sel_c == 2'd0)); // R6

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!prev_rst && $stable(bnd_cmp) && $stable(mode_code) && $stable(trip_active)
         && !oc_event && !trip_active)
        |=> ($stable(sel_a) && $stable(sel_b) && $stable(sel_c))); // R9

    always @(posedge clk) begin
        if (!rst) begin
            AST_CODE_LEGAL: assert (sel_a != 2'd3 && sel_b != 2'd3 && sel_c != 2'd3); // R2
        end
    end
endmodule

bind mxc_pulse_decoder mxc_pulse_decoder_chk #(.NB(NB)) u_chk (.*);

// File: tb/mxc_pulse_decoder_tb.sv
`timescale 1ns/1ps
module mxc_pulse_decoder_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] bnd_cmp = 4'b0000;
    logic [5:0] mode_code = 6'o11;
    logic       oc_event = 1'b0;
    logic       trip_reset = 1'b0;
    logic [1:0] sel_a, sel_b, sel_c;
    logic       trip_active;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    mxc_pulse_decoder u_dut (
        .clk         (clk),
        .rst         (rst),
        .bnd_cmp     (bnd_cmp),
        .mode_code   (mode_code),
        .oc_event    (oc_event),
        .trip_reset  (trip_reset),
        .sel_a       (sel_a),
        .sel_b       (sel_b),
        .sel_c       (sel_c),
        .trip_active (trip_active)
    );

    // {mode, compare flags, expected {A,B,C}}; phases a=0 b=1 c=2
    localparam int NV = 25;
    localparam logic [15:0] VEC [NV] = '{
        {6'o11, 4'b0000, 6'b00_01_00}, {6'o11, 4'b0001, 6'b00_01_01},
        {6'o11, 4'b0011, 6'b00_10_10}, {6'o11, 4'b0111, 6'b00_10_00},
        {6'o11, 4'b1111, 6'b00_00_00},
        {6'o32, 4'b0000, 6'b00_00_10}, {6'o32, 4'b0001, 6'b10_00_10},
        {6'o32, 4'b0011, 6'b10_01_10}, {6'o32, 4'b0111, 6'b01_01_10},
        {6'o32, 4'b1111, 6'b10_10_10},
        {6'o64, 4'b0000, 6'b00_00_01}, {6'o64, 4'b0001, 6'b01_00_01},
        {6'o64, 4'b0011, 6'b10_00_10}, {6'o64, 4'b0111, 6'b00_00_10},
        {6'o64, 4'b1111, 6'b00_00_00},
        {6'o46, 4'b0000, 6'b01_10_01}, {6'o46, 4'b0001, 6'b01_10_10},
        {6'o46, 4'b0011, 6'b01_00_00}, {6'o46, 4'b0111, 6'b01_00_01},
        {6'o46, 4'b1111, 6'b01_01_01},
        {6'o25, 4'b0000, 6'b10_00_00}, {6'o25, 4'b0001, 6'b10_10_00},
        {6'o25, 4'b0011, 6'b10_10_01}, {6'o25, 4'b0111, 6'b10_01_01},
        {6'o25, 4'b1111, 6'b10_10_10}
    };

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk_sel(input string tag, input logic [5:0] exp);
        logic [5:0] got;
        got = {sel_a, sel_b, sel_c};
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: sel got %b expected %b", tag, got, exp);
        end
    endtask

    task automatic chk_trip(input string tag, input logic exp);
        n_chk++;
        if (trip_active !== exp) begin
            n_fail++;
            $display("FAIL %s: trip_active got %b expected %b", tag, trip_active, exp);
        end
    endtask

    task automatic apply(input logic [5:0] m, input logic [3:0] c);
        mode_code = m;
        bnd_cmp   = c;
        step();
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired (R1 run incomplete): got timeout expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        step();
        step();
        // R1 reset state
        chk_sel("R1 reset selects", 6'b00_00_00);
        chk_trip("R1 reset trip", 1'b0);
        rst = 1'b0;

        // R4 / R5 / R2 table of modes and intervals
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][15:10], VEC[i][9:6]);
            if (VEC[i][9]) chk_sel($sformatf("R5 zero vec %0d", i), VEC[i][5:0]);
            else           chk_sel($sformatf("R4 active vec %0d", i), VEC[i][5:0]);
        end

        // R3 non-thermometer compare patterns, mode (1,1)
        apply(6'o11, 4'b0101); chk_sel("R3 pattern 0101", 6'b00_10_00);
        apply(6'o11, 4'b0010); chk_sel("R3 pattern 0010", 6'b00_10_10);
        apply(6'o32, 4'b0001); chk_sel("R3 setup", 6'b10_00_10);
        apply(6'o32, 4'b1010); chk_sel("R3 pattern 1010", 6'b10_10_10);

        // R6 invalid sector codes
        apply(6'o46, 4'b0000); chk_sel("R6 setup", 6'b01_10_01);
        apply(6'o01, 4'b0000); chk_sel("R6 output sector 0", 6'b00_00_00);
        apply(6'o46, 4'b0001); chk_sel("R6 setup2", 6'b01_10_10);
        apply(6'o17, 4'b0001); chk_sel("R6 input sector 7", 6'b00_00_00);

        // R9 outputs steady under steady inputs
        apply(6'o46, 4'b0011); chk_sel("R9 first", 6'b01_00_00);
        step(); chk_sel("R9 held", 6'b01_00_00);
        step(); chk_sel("R9 held again", 6'b01_00_00);

        // R7 trip forces input a
        apply(6'o32, 4'b0111); chk_sel("R7 before trip", 6'b01_01_10);
        oc_event = 1'b1;
        step();
        chk_sel("R7 forced on event edge", 6'b00_00_00);
        chk_trip("R7 latch set", 1'b1);
        oc_event = 1'b0;

        // R8 latch holds
        apply(6'o32, 4'b0001); chk_sel("R8 hold 1", 6'b00_00_00);
        apply(6'o32, 4'b0011); chk_sel("R8 hold 2", 6'b00_00_00);
        chk_trip("R8 still latched", 1'b1);
        oc_event = 1'b1; trip_reset = 1'b1;
        step();
        chk_trip("R8 set wins over clear", 1'b1);
        chk_sel("R8 forced during conflict", 6'b00_00_00);
        oc_event = 1'b0;
        step();
        chk_trip("R8 cleared", 1'b0);
        chk_sel("R8 forced on clearing edge", 6'b00_00_00);
        trip_reset = 1'b0;
        step();
        chk_sel("R8 normal after clear", 6'b10_01_10);

        // R1 reset mid-run
        apply(6'o46, 4'b0000); chk_sel("R1 setup", 6'b01_10_01);
        oc_event = 1'b1;
        step();
        oc_event = 1'b0;
        rst = 1'b1;
        step();
        chk_sel("R1 mid-run reset selects", 6'b00_00_00);
        chk_trip("R1 mid-run reset trip", 1'b0);
        rst = 1'b0;
        step();
        chk_sel("R1 after reset release", 6'b01_10_01);

        finish_run();
    end
endmodule